// File: doc/BRIEF.md
# Single-Transfer Multiplexed Bus Initiator

This block is the initiator side of a 32-bit synchronous bus on which address and data share one set of lines. A local client hands it one request at a time: address, memory or I/O space, direction, byte enables and write data. The block runs the whole bus handshake for a single transfer and reports back with a one-clock completion pulse. The pulse carries the read data and a flag that says whether the cycle was claimed or aborted.

On the bus, the block drives four things: the active-low frame strobe, the active-low initiator-ready strobe, the command/byte-enable lines, and the address/data lines. The address/data lines are split into an output, an output-enable and an input, and the tristate sits outside the block. The block watches the target's active-low device-select and target-ready strobes. It leaves the shared lines undriven for reads so that the target can turn them around. A target may stretch a transfer with wait states. If no target claims the address within a fixed window, the block ends the cycle as a master abort.

Top module: `pbus_initiator`

## Requirements
- R1: After reset, `req_ready` is 1, `frame_n` and `irdy_n` are 1, `ad_oe` is 0 and `done_valid` is 0. A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the clock after the completion pulse. `req_valid` asserted while busy starts no bus cycle, and it does not change the request already taken.
- R2: The clock after acceptance is the address phase, and it lasts exactly one clock. In it, `frame_n`=0, `irdy_n`=1, `ad_oe`=1 and `ad_out` carries the request address. `cbe_n` carries the command: 4'b0110 for a memory read, 4'b0111 for a memory write, 4'b0010 for an I/O read and 4'b0011 for an I/O write. Bit 0 is the write flag.
- R3: In every data-phase clock, `frame_n`=1 (last transfer), `irdy_n`=0 and `cbe_n` is the bitwise inverse of the request byte enables.
- R4: During a read data phase `ad_oe` is 0. During a write data phase `ad_oe` is 1 and `ad_out` holds the write data.
- R5: The transfer completes on the first rising edge in the data phase at which `devsel_n` and `trdy_n` are both 0. A read captures `ad_in` at that edge. The completion pulse follows one clock later with `done_abort`=0 and `done_rdata` holding the read data, or 0 for a write.
- R6: Data-phase clocks are counted from 1. If `devsel_n` is still 1 at the end of data clock 6 (`DEVSEL_LIMIT`), the cycle ends at that edge as a master abort: the pulse follows with `done_abort`=1 and `done_rdata`=32'hFFFF_FFFF. A claim seen in data clock 6 prevents the abort.
- R7: After completion or abort there is one clock in which `frame_n`=1, `irdy_n`=1, `ad_oe`=0 and `cbe_n`=4'hF. `done_valid` is 1 for exactly that clock and `req_ready` is 0 in it. The block is idle again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Request address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| done_valid | output | 1 | One-clock completion pulse |
| done_abort | output | 1 | Cycle ended unclaimed |
| done_rdata | output | 32 | Read data, all-ones on abort, 0 for writes |
| frame_n | output | 1 | Frame strobe, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| cbe_n | output | 4 | Command in address phase, inverted byte enables in data phase |
| ad_out | output | 32 | Address/data value driven onto the bus |
| ad_oe | output | 1 | Enable for `ad_out` onto the shared lines |
| ad_in | input | 32 | Value seen on the shared address/data lines |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |

## Verification
Take the falling edge at which a request is presented as edge 0. The address phase is then visible at falling edge 1, and data clock k at falling edge 1+k. The completion pulse is visible at falling edge 2+kc, where kc is the data clock in which the target gives ready, or 6 for an abort. The bench counts falling edges from the request and compares that count with 2+kc. It works out kc in advance from the device-select delay, the wait states, and the rule that read ready cannot come before data clock 2. The behavioural target samples and drives the bus only on falling edges, so every bus-field check lands mid-cycle, in the phase it belongs to. The next falling edge after the pulse confirms that `req_ready` has returned.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int BUS_W = 32;
    localparam int BE_W  = BUS_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BE_W-1:0]  be;
        logic [BUS_W-1:0] wdata;
        logic             io;
        logic             write;
    } xfer_req_t;

    // command: bit2 set for memory space, bit1 always set, bit0 = write
    function automatic logic [BE_W-1:0] cmd_code(input logic io, input logic write);
        logic [BE_W-1:0] c;
        c = '0;
        c[2] = ~io;
        c[1] = 1'b1;
        c[0] = write;
        return c;
    endfunction

endpackage

// File: rtl/pbus_claim_timer.sv
module pbus_claim_timer #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic devsel_n,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else begin
            if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
            seen <= seen | ~devsel_n;
        end
    end

    // cnt holds the number of data clocks already elapsed
    assign expired = run && !seen && devsel_n && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  xfer_req_t        req,
    input  logic             expired,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic [BUS_W-1:0] ad_in,
    output seq_state_e       state,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [BE_W-1:0]  cbe_n,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             done_valid,
    output logic             done_abort,
    output logic [BUS_W-1:0] done_rdata
);
    logic xfer_hit;
    assign xfer_hit = !devsel_n && !trdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done_abort <= 1'b0;
            done_rdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) state <= ST_ADDR;
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (xfer_hit) begin
                        done_abort <= 1'b0;
                        done_rdata <= req.write ? '0 : ad_in;
                        state      <= ST_DONE;
                    end else if (expired) begin
                        done_abort <= 1'b1;
                        done_rdata <= '1;
                        state      <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        frame_n = 1'b1;
        irdy_n  = 1'b1;
        cbe_n   = '1;
        ad_out  = '0;
        ad_oe   = 1'b0;
        unique case (state)
            ST_ADDR: begin
                frame_n = 1'b0;
                cbe_n   = ~cmd_code(req.io, req.write);
                cbe_n   = ~cbe_n;
                ad_out  = req.addr;
                ad_oe   = 1'b1;
            end
            ST_DATA: begin
                irdy_n = 1'b0;
                cbe_n  = ~req.be;
                if (req.write) begin
                    ad_oe  = 1'b1;
                    ad_out = req.wdata;
                end
            end
            default: ;
        endcase
    end

    assign done_valid = (state == ST_DONE);

endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
    import pbus_pkg::*;
#(
    parameter int DEVSEL_LIMIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUS_W-1:0] req_addr,
    input  logic             req_io,
    input  logic             req_write,
    input  logic [BE_W-1:0]  req_be,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             done_valid,
    output logic             done_abort,
    output logic [BUS_W-1:0] done_rdata,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [BE_W-1:0]  cbe_n,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    input  logic [BUS_W-1:0] ad_in,
    input  logic             devsel_n,
    input  logic             trdy_n
);
    seq_state_e state;
    xfer_req_t  held;
    logic       start;
    logic       expired;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (start) begin
            held.addr  <= req_addr;
            held.be    <= req_be;
            held.wdata <= req_wdata;
            held.io    <= req_io;
            held.write <= req_write;
        end
    end

    pbus_claim_timer #(.LIMIT(DEVSEL_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state == ST_DATA),
        .devsel_n (devsel_n),
        .expired  (expired)
    );

    pbus_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req        (held),
        .expired    (expired),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .ad_in      (ad_in),
        .state      (state),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .cbe_n      (cbe_n),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .done_valid (done_valid),
        .done_abort (done_abort),
        .done_rdata (done_rdata)
    );

endmodule

// File: rtl/pbus_initiator_chk.sv
module pbus_initiator_chk #(
    parameter int LIMIT = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        done_valid,
    input logic        done_abort,
    input logic [31:0] done_rdata,
    input logic        frame_n,
    input logic        irdy_n,
    input logic [3:0]  cbe_n,
    input logic        ad_oe,
    input logic        devsel_n
);
    int unsigned nodev_cnt;

    always_ff @(posedge clk) begin
        if (rst || irdy_n || !devsel_n) nodev_cnt <= 0;
        else                            nodev_cnt <= nodev_cnt + 1;
    end

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (frame_n && irdy_n && !ad_oe));

    assert_addr_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (frame_n && !irdy_n));

    assert_addr_drives_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> (irdy_n && ad_oe));

    assert_read_float_R4: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && $past(!frame_n) && !$past(cbe_n[0])) |-> !ad_oe);

    assert_abort_window_R6: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && devsel_n) |-> (nodev_cnt < LIMIT));

    assert_abort_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_abort) |-> (done_rdata == 32'hFFFF_FFFF));

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (frame_n && irdy_n && !ad_oe && cbe_n == 4'hF && !req_ready));

    assert_pulse_once_R7: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));

endmodule

bind pbus_initiator pbus_initiator_chk #(.LIMIT(DEVSEL_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_abort (done_abort),
    .done_rdata (done_rdata),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .cbe_n      (cbe_n),
    .ad_oe      (ad_oe),
    .devsel_n   (devsel_n)
);

// File: tb/pbus_initiator_tb.sv
module pbus_initiator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ABORT_CLK  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        done_valid, done_abort;
    logic [31:0] done_rdata;
    logic        frame_n, irdy_n, ad_oe;
    logic [3:0]  cbe_n;
    logic [31:0] ad_out;
    logic [31:0] tgt_ad = '0;
    logic        tgt_devsel_n = 1'b1;
    logic        tgt_trdy_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_initiator u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_io(req_io), .req_write(req_write),
        .req_be(req_be), .req_wdata(req_wdata),
        .done_valid(done_valid), .done_abort(done_abort), .done_rdata(done_rdata),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(tgt_ad),
        .devsel_n(tgt_devsel_n), .trdy_n(tgt_trdy_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // expectation of the transfer in flight
    logic [31:0] e_addr, e_wdata;
    logic [3:0]  e_be;
    logic        e_io, e_wr, e_claim;
    int          e_dly, e_wt;
    int          t_k = 0;
    bit          t_active = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input logic io, input logic wr);
        return {1'b0, ~io, 1'b1, wr};
    endfunction

    function automatic logic [31:0] tgt_data(input logic [31:0] a);
        return a ^ 32'hA5A5_5A5A;
    endfunction

    function automatic int ready_clk(input int dly, input int wt, input logic wr);
        int k;
        k = dly + wt;
        if (!wr && k < 2) k = 2;   // read turnaround clock
        return k;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // behavioural target, acts mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (!frame_n && irdy_n) begin
                chk(ad_oe == 1'b1, "R2 addr oe", {31'd0, ad_oe}, 32'd1);
                chk(ad_out == e_addr, "R2 addr", ad_out, e_addr);
                chk(cbe_n == exp_cmd(e_io, e_wr), "R2 cmd", {28'd0, cbe_n}, {28'd0, exp_cmd(e_io, e_wr)});
                t_active = 1;
                t_k = 0;
                tgt_devsel_n = 1'b1;
                tgt_trdy_n = 1'b1;
            end else if (t_active && !irdy_n) begin
                t_k++;
                chk(frame_n == 1'b1, "R3 frame", {31'd0, frame_n}, 32'd1);
                chk(cbe_n == ~e_be, "R3 be", {28'd0, cbe_n}, {28'd0, ~e_be});
                chk(ad_oe == e_wr, "R4 oe", {31'd0, ad_oe}, {31'd0, e_wr});
                if (e_claim && t_k >= e_dly) tgt_devsel_n = 1'b0;
                if (e_claim && t_k >= ready_clk(e_dly, e_wt, e_wr)) begin
                    tgt_trdy_n = 1'b0;
                    if (e_wr) chk(ad_out == e_wdata, "R4 wdata", ad_out, e_wdata);
                    else      tgt_ad = tgt_data(e_addr);
                end
            end else if (t_active) begin
                t_active = 0;
                tgt_devsel_n = 1'b1;
                tgt_trdy_n = 1'b1;
                tgt_ad = '0;
                chk(frame_n && irdy_n && !ad_oe && cbe_n == 4'hF, "R7 release",
                    {frame_n, irdy_n, ad_oe, cbe_n}, {3'b110, 4'hF});
            end
        end
    end

    task automatic run_txn(input logic [31:0] addr, input logic io, input logic wr,
                           input logic [3:0] be, input logic [31:0] wd,
                           input int dly, input int wt, input bit hold_busy);
        int n, kc;
        logic [31:0] er;
        e_addr = addr; e_io = io; e_wr = wr; e_be = be; e_wdata = wd;
        e_claim = (addr[31:28] != 4'hF);
        e_dly = dly; e_wt = wt;
        kc = e_claim ? ready_clk(dly, wt, wr) : ABORT_CLK;
        er = !e_claim ? 32'hFFFF_FFFF : (wr ? 32'd0 : tgt_data(addr));
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = addr; req_io = io; req_write = wr;
        req_be = be; req_wdata = wd;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 busy", {31'd0, req_ready}, 32'd0);
        if (hold_busy) begin
            req_addr = ~addr; req_be = ~be; req_wdata = ~wd; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        n = 1;
        while (!done_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n == 2 + kc, e_claim ? "R5 latency" : "R6 latency", n, 2 + kc);
        chk(done_abort == !e_claim, "R6 abort flag", {31'd0, done_abort}, {31'd0, !e_claim});
        chk(done_rdata == er, e_claim ? "R5 rdata" : "R6 rdata", done_rdata, er);
        chk(req_ready == 1'b0, "R7 ready in pulse", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk(done_valid == 1'b0 && req_ready == 1'b1, "R7 pulse width",
            {30'd0, done_valid, req_ready}, 32'd1);
        if (hold_busy)
            chk(frame_n == 1'b1, "R1 no start while busy", {31'd0, frame_n}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && frame_n && irdy_n && !ad_oe && !done_valid, "R1 reset",
            {27'd0, req_ready, frame_n, irdy_n, ad_oe, done_valid}, 32'b11100);

        // directed corners
        run_txn(32'h1000_0040, 1'b0, 1'b1, 4'hF, 32'hCAFE_0001, 1, 0, 0); // fastest write
        run_txn(32'h1000_0080, 1'b0, 1'b0, 4'h3, 32'h0,         1, 0, 0); // read waits turnaround
        run_txn(32'h2000_0004, 1'b1, 1'b0, 4'h1, 32'h0,         6, 0, 0); // claim on last clock
        run_txn(32'h2000_0008, 1'b1, 1'b1, 4'h8, 32'h1234_5678, 6, 3, 0); // late claim plus waits
        run_txn(32'hF000_0100, 1'b0, 1'b0, 4'hF, 32'h0,         1, 0, 0); // unclaimed read
        run_txn(32'hF123_4560, 1'b1, 1'b1, 4'h5, 32'h5555_AAAA, 1, 0, 0); // unclaimed write
        run_txn(32'h3000_0010, 1'b0, 1'b0, 4'hC, 32'h0,         2, 2, 1); // request held while busy

        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(3) == 0) a[31:28] = 4'hF;
            else a[31:28] = 4'($urandom_range(14));
            run_txn(a, 1'($urandom_range(1)), 1'($urandom_range(1)), 4'($urandom),
                    $urandom, $urandom_range(6, 1), $urandom_range(3), 1'($urandom_range(3) == 0));
        end
        finish_run();
    end
endmodule